// File: doc/BRIEF.md
# Nibble ALU with Flag Unit

This block is the arithmetic core of a small 4-bit controller. Each cycle it takes an operation code, the accumulator value and a second operand. It returns the result combinationally in the same cycle, together with a write strobe that tells the sequencer whether the accumulator or memory should take the result. Four flags are kept in registers inside the block: carry, zero, status and general. A flag update is applied on the clock edge that ends the operation, so the new flags are visible from the following cycle.

The status flag is the branch condition for the surrounding sequencer. Arithmetic copies the new carry into it. Two test operations move carry into status and then force carry to a fixed value. In subtraction and comparison the carry is an inverted borrow. A small last-in first-out frame holds flag snapshots, so that interrupt entry can save all four flags and the return from interrupt can restore them. Register file access and instruction sequencing are outside this block.

Top module: `nib_alu_flags`

## Requirements
- R1: While rst_n is low and after its release, before any other operation, the flags are carry=0, zero=0, status=1 and general=0, and the save frame is empty.
- R2: Code 0 (add) returns (acc+opnd) mod 16. Code 1 (add with carry) returns (acc+opnd+carry) mod 16. Both assert res_we and set carry to the carry-out of the 4-bit sum.
- R3: Code 2 (subtract) returns (acc-opnd) mod 16 with res_we asserted. Carry becomes 1 when acc >= opnd (no borrow) and 0 when a borrow occurs.
- R4: Code 3 (compare) updates carry, zero and status exactly as code 2 would, and it keeps res_we low.
- R5: After codes 0 to 3, the status flag equals the newly written carry flag.
- R6: Code 4 (rotate left through carry) returns {acc[2:0], carry} and loads acc[3] into carry. Code 5 (rotate right through carry) returns {carry, acc[3:1]} and loads acc[0] into carry. Both assert res_we and leave status unchanged.
- R7: Codes 0 to 8 set the zero flag to 1 exactly when their 4-bit result is 0. Codes 9 to 15 leave the zero flag unchanged.
- R8: Codes 6, 7 and 8 return acc AND, OR and XOR opnd with res_we asserted. They leave carry, status and general unchanged.
- R9: Code 9 copies carry into status and then clears carry. Code 10 copies carry into status and then sets carry. Neither asserts res_we.
- R10: Code 11 sets the general flag and code 12 clears it. Code 13 copies the general flag into status and leaves the general flag unchanged.
- R11: A save pushes all four current flags onto the frame. A restore pops the most recent snapshot back into the flags. The frame nests last-in first-out up to FRAME_DEPTH levels (default 4).
- R12: Restore takes priority over save, and save takes priority over an operation. In a save or restore cycle the operation is ignored and res_we is low. A save into a full frame changes nothing. A restore from an empty frame leaves the flags unchanged.
- R13: Codes 14 and 15, and any cycle with op_valid low, leave all flags unchanged and keep res_we low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation code |
| acc_in | input | 4 | Accumulator operand |
| opnd_in | input | 4 | Second operand |
| flag_save | input | 1 | Push all flags onto the frame |
| flag_restore | input | 1 | Pop the frame into the flags |
| res_out | output | 4 | Operation result (combinational) |
| res_we | output | 1 | The result is to be written back |
| cf_out | output | 1 | Carry flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Status flag |
| gf_out | output | 1 | General flag |

## Verification
The hardest situations to reach from the ports are the edges of the frame: a save into a full frame, and a restore from an empty one, where the only trace left is that the flags do not change. Random traffic rarely builds a run of five saves. The stimulus therefore has directed bursts. Each burst gives every level distinct flags, overfills the frame, and then drains it past empty, so that every popped snapshot identifies the level it came from. Random operations follow. Save and restore are mixed in at a low rate so that nesting interleaves with flag-changing operations, and everything is compared against a bench model of the flags and the frame.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_RLC  = 4'd4,
        OP_RRC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_TCLR = 4'd9,
        OP_TSET = 4'd10,
        OP_GSET = 4'd11,
        OP_GCLR = 4'd12,
        OP_GTST = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic gf;
    } flags_t;

    localparam flags_t FLAGS_RST = '{cf: 1'b0, zf: 1'b0, sf: 1'b1, gf: 1'b0};

endpackage

// File: rtl/nib_alu_core.sv
module nib_alu_core
    import nib_alu_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  flags_t              f_in,
    output logic [DATA_W-1:0]   res,
    output logic                res_wr,
    output flags_t              f_out
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] dif_ext;
    logic             cin;

    always_comb begin
        cin     = (op == OP_ADDC) ? f_in.cf : 1'b0;
        sum_ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        // top bit of dif_ext set means a borrow was taken
        dif_ext = {1'b0, a} - {1'b0, b};

        res    = a;
        res_wr = 1'b0;
        f_out  = f_in;

        case (op)
            OP_ADD, OP_ADDC: begin
                res      = sum_ext[DATA_W-1:0];
                res_wr   = 1'b1;
                f_out.cf = sum_ext[DATA_W];
                f_out.sf = sum_ext[DATA_W];
                f_out.zf = (sum_ext[DATA_W-1:0] == '0);
            end
            OP_SUB, OP_CMP: begin
                res      = dif_ext[DATA_W-1:0];
                res_wr   = (op == OP_SUB);
                f_out.cf = ~dif_ext[DATA_W];
                f_out.sf = ~dif_ext[DATA_W];
                f_out.zf = (dif_ext[DATA_W-1:0] == '0);
            end
            OP_RLC: begin
                res      = {a[DATA_W-2:0], f_in.cf};
                res_wr   = 1'b1;
                f_out.cf = a[DATA_W-1];
                f_out.zf = ({a[DATA_W-2:0], f_in.cf} == '0);
            end
            OP_RRC: begin
                res      = {f_in.cf, a[DATA_W-1:1]};
                res_wr   = 1'b1;
                f_out.cf = a[0];
                f_out.zf = ({f_in.cf, a[DATA_W-1:1]} == '0);
            end
            OP_AND: begin
                res      = a & b;
                res_wr   = 1'b1;
                f_out.zf = ((a & b) == '0);
            end
            OP_OR: begin
                res      = a | b;
                res_wr   = 1'b1;
                f_out.zf = ((a | b) == '0);
            end
            OP_XOR: begin
                res      = a ^ b;
                res_wr   = 1'b1;
                f_out.zf = ((a ^ b) == '0);
            end
            OP_TCLR: begin
                f_out.sf = f_in.cf;
                f_out.cf = 1'b0;
            end
            OP_TSET: begin
                f_out.sf = f_in.cf;
                f_out.cf = 1'b1;
            end
            OP_GSET: f_out.gf = 1'b1;
            OP_GCLR: f_out.gf = 1'b0;
            OP_GTST: f_out.sf = f_in.gf;
            default: begin
                res    = a;
                res_wr = 1'b0;
                f_out  = f_in;
            end
        endcase
    end

    // R4: compare never requests a write
    always_comb begin
        assert_cmp_core_R4: assert (!(op == OP_CMP && res_wr));
    end

endmodule

// File: rtl/nib_flag_frame.sv
module nib_flag_frame
    import nib_alu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  flags_t push_flags,
    output flags_t top_flags,
    output logic   empty,
    output logic   full
);

    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);

    flags_t           mem_q [DEPTH];
    flags_t           mem_d [DEPTH];
    logic [PTR_W-1:0] cnt_q;
    logic [PTR_W-1:0] cnt_d;
    logic [PTR_W-1:0] top_ptr;
    logic [PTR_W-1:0] wr_ptr;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign top_ptr = cnt_q - 1'b1;
    assign wr_ptr  = cnt_q;
    assign top_flags = empty ? FLAGS_RST : mem_q[top_ptr[IDX_W-1:0]];

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        if (pop) begin
            if (!empty) cnt_d = cnt_q - 1'b1;
        end else if (push && !full) begin
            mem_d[wr_ptr[IDX_W-1:0]] = push_flags;
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= FLAGS_RST;
            else        mem_q[i] <= mem_d[i];
        end
    end

    // R12: a push into a full frame keeps it full and does not grow it
    assert_push_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> full);

    // R11: a pop from a non-empty frame frees exactly one level
    assert_pop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nib_alu_flags.sv
module nib_alu_flags
    import nib_alu_pkg::*;
#(
    parameter int DATA_W      = 4,
    parameter int FRAME_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              flag_save,
    input  logic              flag_restore,
    output logic [DATA_W-1:0] res_out,
    output logic              res_we,
    output logic              cf_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              gf_out
);

    alu_op_e           op;
    flags_t            flags_q;
    flags_t            flags_d;
    flags_t            core_flags;
    flags_t            fr_top;
    logic [DATA_W-1:0] core_res;
    logic              core_wr;
    logic              fr_empty;
    logic              fr_full;
    logic              exec;
    logic              is_arith;
    logic              is_logic;
    logic              has_result;

    assign op         = alu_op_e'(op_code);
    assign exec       = op_valid && !flag_save && !flag_restore;
    assign is_arith   = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_CMP);
    assign is_logic   = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    assign has_result = (op_code <= 4'd8);

    nib_alu_core #(.DATA_W(DATA_W)) u_core (
        .op     (op),
        .a      (acc_in),
        .b      (opnd_in),
        .f_in   (flags_q),
        .res    (core_res),
        .res_wr (core_wr),
        .f_out  (core_flags)
    );

    nib_flag_frame #(.DEPTH(FRAME_DEPTH)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (flag_save),
        .pop        (flag_restore),
        .push_flags (flags_q),
        .top_flags  (fr_top),
        .empty      (fr_empty),
        .full       (fr_full)
    );

    always_comb begin
        flags_d = flags_q;
        if (flag_restore) begin
            if (!fr_empty) flags_d = fr_top;
        end else if (flag_save) begin
            flags_d = flags_q;
        end else if (op_valid) begin
            flags_d = core_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RST;
        else        flags_q <= flags_d;
    end

    assign res_out = core_res;
    assign res_we  = exec && core_wr;
    assign cf_out  = flags_q.cf;
    assign zf_out  = flags_q.zf;
    assign sf_out  = flags_q.sf;
    assign gf_out  = flags_q.gf;

    // R1: reset leaves the status flag set
    assert_sf_reset_R1: assert property (@(posedge clk)
        !rst_n |=> sf_out);

    // R4: compare never writes back
    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_CMP) |-> !res_we);

    // R5: status tracks the new carry after arithmetic
    assert_sf_follows_cf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && is_arith) |=> (sf_out == cf_out));

    // R7: zero flag reflects the result of the operation
    assert_zf_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && has_result) |=> (zf_out == ($past(res_out) == '0)));

    // R8: logic operations keep carry
    assert_logic_keeps_cf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && is_logic) |=> $stable(cf_out));

    // R9: test-and-clear moves carry into status
    assert_test_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_TCLR) |=> (!cf_out && sf_out == $past(cf_out)));

    // R12: restore from an empty frame changes nothing
    assert_restore_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_restore && fr_empty) |=> ($stable(cf_out) && $stable(zf_out)
                                        && $stable(sf_out) && $stable(gf_out)));

    // R12: no write-back in save or restore cycles
    assert_no_write_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_save || flag_restore) |-> !res_we);

    // R13: reserved codes keep the flags
    assert_reserved_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_code >= 4'd14) |=> ($stable(cf_out) && $stable(zf_out)
                                        && $stable(sf_out) && $stable(gf_out)));

endmodule

// File: tb/tb_nib_alu_flags.sv
module tb_nib_alu_flags;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [3:0] acc_in = '0;
    logic [3:0] opnd_in = '0;
    logic       flag_save = 1'b0;
    logic       flag_restore = 1'b0;
    logic [3:0] res_out;
    logic       res_we;
    logic       cf_out, zf_out, sf_out, gf_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model: flags packed {cf,zf,sf,gf}
    logic [3:0] m_fl;
    logic [3:0] m_stk [DEPTH];
    int         m_sp;

    always #10 clk = ~clk;

    nib_alu_flags #(.DATA_W(4), .FRAME_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .flag_save(flag_save),
        .flag_restore(flag_restore), .res_out(res_out), .res_we(res_we),
        .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out), .gf_out(gf_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op, input bit sv, input bit rs);
        if (rs || sv) return "R11/R12";
        case (op)
            4'd0, 4'd1: return "R2";
            4'd2:       return "R3";
            4'd3:       return "R4";
            4'd4, 4'd5: return "R6";
            4'd6, 4'd7, 4'd8: return "R8";
            4'd9, 4'd10: return "R9";
            4'd11, 4'd12, 4'd13: return "R10";
            default:    return "R13";
        endcase
    endfunction

    // expected result, write strobe and next flags for one operation
    task automatic model_op(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                            output logic [3:0] r, output bit we, output logic [3:0] nf);
        logic cf, zf, sf, gf;
        logic [4:0] s;
        {cf, zf, sf, gf} = m_fl;
        r = a; we = 0;
        case (op)
            4'd0, 4'd1: begin
                s = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? {4'd0, cf} : 5'd0);
                r = s[3:0]; we = 1; cf = s[4]; sf = s[4]; zf = (r == 0);
            end
            4'd2, 4'd3: begin
                r = a - b; we = (op == 4'd2); cf = (a >= b); sf = cf; zf = (r == 0);
            end
            4'd4: begin r = {a[2:0], cf}; we = 1; cf = a[3]; zf = (r == 0); end
            4'd5: begin r = {cf, a[3:1]}; we = 1; cf = a[0]; zf = (r == 0); end
            4'd6: begin r = a & b; we = 1; zf = (r == 0); end
            4'd7: begin r = a | b; we = 1; zf = (r == 0); end
            4'd8: begin r = a ^ b; we = 1; zf = (r == 0); end
            4'd9:  begin sf = cf; cf = 0; end
            4'd10: begin sf = cf; cf = 1; end
            4'd11: gf = 1;
            4'd12: gf = 0;
            4'd13: sf = gf;
            default: ;
        endcase
        nf = {cf, zf, sf, gf};
    endtask

    task automatic run(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                       input bit sv, input bit rs, input bit vld = 1);
        logic [3:0] r, nf;
        bit we;
        string req;
        @(negedge clk);
        op_valid = vld; op_code = op; acc_in = a; opnd_in = b;
        flag_save = sv; flag_restore = rs;
        model_op(op, a, b, r, we, nf);
        req = req_of(op, sv, rs);
        if (!vld) req = "R13";
        #1;
        if (rs || sv || !vld) begin
            chk({req, " res_we"}, int'(res_we), 0);
        end else begin
            chk({req, " res_we"}, int'(res_we), int'(we));
            if (we) chk({req, " result"}, int'(res_out), int'(r));
        end
        // model state update
        if (rs) begin
            if (m_sp > 0) begin m_sp--; m_fl = m_stk[m_sp]; end
        end else if (sv) begin
            if (m_sp < DEPTH) begin m_stk[m_sp] = m_fl; m_sp++; end
        end else if (vld) begin
            m_fl = nf;
        end
        @(posedge clk);
        #1;
        chk({req, (op <= 4'd3 && !sv && !rs && vld) ? " flags(R5,R7)" : " flags(R7)"},
            int'({cf_out, zf_out, sf_out, gf_out}), int'(m_fl));
        op_valid = 0; flag_save = 0; flag_restore = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_fl = 4'b0010; m_sp = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flags", int'({cf_out, zf_out, sf_out, gf_out}), 2);
        chk("R1 reset res_we", int'(res_we), 0);
        @(negedge clk) rst_n = 1'b1;
        // R1: frame starts empty, a restore must change nothing
        run(4'd0, 4'd0, 4'd0, 0, 1);

        // directed corner cases
        run(4'd0, 4'd9, 4'd7, 0, 0);   // R2 wrap to zero with carry
        run(4'd1, 4'd7, 4'd8, 0, 0);   // R2 add with carry in
        run(4'd2, 4'd3, 4'd5, 0, 0);   // R3 borrow
        run(4'd2, 4'd5, 4'd5, 0, 0);   // R3 equal, no borrow
        run(4'd3, 4'd2, 4'd9, 0, 0);   // R4 compare
        run(4'd4, 4'd8, 4'd0, 0, 0);   // R6 rotate left out of msb
        run(4'd5, 4'd1, 4'd0, 0, 0);   // R6 rotate right
        run(4'd6, 4'd12, 4'd3, 0, 0);  // R8 and to zero
        run(4'd10, 4'd0, 4'd0, 0, 0);  // R9 set carry
        run(4'd9, 4'd0, 4'd0, 0, 0);   // R9 clear carry
        run(4'd11, 4'd0, 4'd0, 0, 0);  // R10 set general
        run(4'd13, 4'd0, 4'd0, 0, 0);  // R10 test general
        run(4'd14, 4'd5, 4'd5, 0, 0);  // R13 reserved
        run(4'd0, 4'd15, 4'd15, 0, 0, 0); // R13 op_valid low

        // frame burst: distinct flags per level, overfill, then drain past empty
        for (int lv = 0; lv < DEPTH + 1; lv++) begin
            run(4'd0, 4'(lv * 5), 4'(lv * 3 + 1), 0, 0);
            run((lv % 2) ? 4'd11 : 4'd12, 4'd0, 4'd0, 0, 0);
            run(4'd0, 4'd0, 4'd0, 1, 0);            // R11 save (R12 on the extra one)
        end
        run(4'd7, 4'd0, 4'd0, 0, 0);                // R7 zero result
        for (int k = 0; k < DEPTH + 2; k++) run(4'd2, 4'd1, 4'd2, 1, 1); // R12 priority + drain

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [3:0] op, a, b;
            bit sv, rs;
            op = 4'($urandom % 16);
            a  = 4'($urandom % 16);
            b  = 4'($urandom % 16);
            sv = ($urandom % 7) == 0;
            rs = ($urandom % 9) == 0;
            run(op, a, b, sv, rs, ($urandom % 10) != 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule